// File: doc/BRIEF.md
# Programmable Asynchronous Character Framer

This block is one line of a multi-line serial controller: an asynchronous transmitter and receiver pair whose character format is set at run time. Software writes a packed 16-bit format word. The word carries a line number, and only the line whose `LINE_ID` parameter matches that number takes the word. The word sets the character length (5 to 8 bits), one or two stop bits, parity on or off, odd or even parity, a 4-bit speed code and a receiver enable.

Bit timing comes from outside the block. A shared baud generator delivers sixteen tick strobes, one per speed code, and each strobe runs at 16 times its bit rate. The framer uses the strobe that its speed code selects. On the transmit side, a one-cycle load strobe takes a parallel character and sends it as a frame. A break input holds the line at the space level. On the receive side, each character comes out with a one-cycle valid pulse, together with a parity error flag and a framing error flag.

Top module: `async_framer`

## Requirements
- R1: `cfg_word` is taken on `cfg_we` only when bits 1:0 equal `LINE_ID`; otherwise it is ignored. Fields: bits 4:3 length (00=5, 01=6, 10=7, 11=8 bits), bit 5 two stop bits, bit 6 parity enable, bit 7 odd parity, bits 11:8 speed code, bit 12 receiver enable. Bits 2 and 15:13 have no effect.
- R2: A transmitted frame is one low start bit, then the data bits LSB first, then the parity bit if parity is enabled, then one or two high stop bits. Each bit lasts 16 ticks of the selected strobe.
- R3: The parity bit makes the count of ones over the data bits and the parity bit even when bit 7 is clear, and odd when bit 7 is set.
- R4: A `tx_load` that is accepted raises `tx_busy` on the next cycle. `tx_busy` stays high until the frame ends. A `tx_load` that arrives while busy is ignored.
- R5: While `tx_break` is high, `txd` is low.
- R6: With no frame in progress and no break, `txd` is high.
- R7: The receiver samples mid-bit and assembles the configured number of data bits into `rx_data`. Unused upper bits are zero. `rx_valid` is a one-cycle pulse.
- R8: `rx_perr` is set with `rx_valid` when parity is enabled and the received parity bit does not match the configured sense.
- R9: `rx_ferr` is set when the first stop bit samples low. A line held low (break) is reported once, and the receiver then waits for the line to return high.
- R10: With the receiver disabled, no `rx_valid` is produced.
- R11: The speed code selects which bit of `os_ticks` paces both directions.
- R12: After reset the format is 8 bits, 1 stop bit, no parity, speed code 0xF, receiver off; `txd` is high, and `tx_busy` and `rx_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Format word write strobe |
| cfg_word | input | 16 | Packed format word |
| os_ticks | input | 16 | 16x oversampling strobes, one per speed code |
| tx_load | input | 1 | Start transmission of `tx_data` |
| tx_data | input | 8 | Character to send |
| tx_break | input | 1 | Force line to space level |
| tx_busy | output | 1 | Frame in progress |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_valid | output | 1 | Received character strobe |
| rx_data | output | 8 | Received character, zero-extended |
| rx_perr | output | 1 | Parity error with `rx_valid` |
| rx_ferr | output | 1 | Framing error or break with `rx_valid` |

## Verification
Some properties hold on every cycle and the assertions check them there: break forcing the line low, the idle line staying high, a start bit being low when busy rises, load acceptance, the single-cycle valid pulse, silence while the receiver is off, and the zeroed upper bits for 5-bit characters. Other behaviour only shows up over whole frames, so the bench scenarios cover it. These are the LSB-first bit order, the parity sense, the stop-bit count, mid-bit sampling, the speed code selection, the single report for a held break, and the rejection of format words addressed to another line.

// File: rtl/framer_pkg.sv
package framer_pkg;
    localparam int SPEED_CODES = 16;

    typedef struct packed {
        logic       rx_en;
        logic [3:0] speed;
        logic       odd;
        logic       par_en;
        logic       stop2;
        logic [1:0] len;
    } line_cfg_t;
endpackage

// File: rtl/framer_cfg.sv
module framer_cfg
    import framer_pkg::*;
#(
    parameter int LINE_ID = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [15:0] word,
    output line_cfg_t   cfg
);
    line_cfg_t cfg_d, cfg_q;
    logic unused_bits;

    assign unused_bits = ^{word[15:13], word[2]};

    always_comb begin
        cfg_d = cfg_q;
        if (we && word[1:0] == 2'(LINE_ID)) begin
            cfg_d.len    = word[4:3];
            cfg_d.stop2  = word[5];
            cfg_d.par_en = word[6];
            cfg_d.odd    = word[7];
            cfg_d.speed  = word[11:8];
            cfg_d.rx_en  = word[12];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q       <= '0;
            cfg_q.len   <= 2'b11;
            cfg_q.speed <= 4'hF;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/framer_tx.sv
module framer_tx
    import framer_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int OS_RATE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  line_cfg_t         cfg,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    input  logic              brk,
    output logic              busy,
    output logic              txd
);
    localparam int FRAME_W = DATA_W + 4;
    localparam int CNT_W   = $clog2(OS_RATE);
    localparam int BIT_W   = $clog2(FRAME_W + 1);
    localparam int MIN_LEN = DATA_W - 3;

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] sh;
        logic [BIT_W-1:0]   left;
        logic [CNT_W-1:0]   sub;
    } tx_state_t;

    tx_state_t q, d;
    logic [FRAME_W-1:0] frame;
    logic [BIT_W-1:0]   nd, nbits;
    logic               par;

    // Frame image: start bit at position 0, stop bits fill the rest with ones
    always_comb begin
        nd    = BIT_W'(MIN_LEN) + BIT_W'(cfg.len);
        frame = '1;
        frame[0] = 1'b0;
        par   = cfg.odd;
        for (int i = 0; i < DATA_W; i++) begin
            if (BIT_W'(i) < nd) begin
                frame[1 + i] = data[i];
                par          = par ^ data[i];
            end
        end
        if (cfg.par_en) frame[1 + nd] = par;
        nbits = BIT_W'(2) + nd + BIT_W'(cfg.par_en) + BIT_W'(cfg.stop2);
    end

    always_comb begin
        d = q;
        if (!q.busy) begin
            if (load) begin
                d.busy = 1'b1;
                d.sh   = frame;
                d.left = nbits;
                d.sub  = '0;
            end
        end else if (tick) begin
            if (q.sub == CNT_W'(OS_RATE - 1)) begin
                d.sub  = '0;
                d.sh   = {1'b1, q.sh[FRAME_W-1:1]};
                d.left = q.left - 1'b1;
                if (q.left == BIT_W'(1)) d.busy = 1'b0;
            end else begin
                d.sub = q.sub + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.busy;
    assign txd  = brk ? 1'b0 : (q.busy ? q.sh[0] : 1'b1);
endmodule

// File: rtl/framer_rx.sv
module framer_rx
    import framer_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int OS_RATE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  line_cfg_t         cfg,
    input  logic              tick,
    input  logic              rxd,
    output logic              valid,
    output logic [DATA_W-1:0] data,
    output logic              perr,
    output logic              ferr
);
    localparam int CNT_W   = $clog2(OS_RATE);
    localparam int BIT_W   = $clog2(DATA_W + 3);
    localparam int MIN_LEN = DATA_W - 3;
    localparam int HALF    = OS_RATE / 2;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_HOLD} rx_st_t;

    typedef struct packed {
        rx_st_t            st;
        logic [CNT_W-1:0]  sub;
        logic [BIT_W-1:0]  idx;
        logic [DATA_W-1:0] sh;
        logic              pbit;
        logic [1:0]        sync;
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
    } rx_state_t;

    rx_state_t q, d;
    logic              line;
    logic [BIT_W-1:0]  nd;
    logic [DATA_W-1:0] word;

    assign line = q.sync[1];
    assign nd   = BIT_W'(MIN_LEN) + BIT_W'(cfg.len);
    assign word = q.sh >> (BIT_W'(DATA_W) - nd);

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        d.sync  = {q.sync[0], rxd};
        if (!cfg.rx_en) begin
            d.st = RX_IDLE;
        end else begin
            case (q.st)
                RX_IDLE: if (tick && !line) begin
                    d.st  = RX_START;
                    d.sub = '0;
                end
                RX_START: if (tick) begin
                    if (q.sub == CNT_W'(HALF - 1)) begin
                        d.sub = '0;
                        d.idx = '0;
                        d.st  = line ? RX_IDLE : RX_BITS;
                    end else begin
                        d.sub = q.sub + 1'b1;
                    end
                end
                RX_BITS: if (tick) begin
                    if (q.sub == CNT_W'(OS_RATE - 1)) begin
                        d.sub = '0;
                        d.idx = q.idx + 1'b1;
                        if (q.idx < nd) begin
                            d.sh = {line, q.sh[DATA_W-1:1]};
                        end else if (cfg.par_en && q.idx == nd) begin
                            d.pbit = line;
                        end else begin
                            d.valid = 1'b1;
                            d.data  = word;
                            d.perr  = cfg.par_en & (^word ^ q.pbit ^ cfg.odd);
                            d.ferr  = ~line;
                            d.st    = line ? RX_IDLE : RX_HOLD;
                        end
                    end else begin
                        d.sub = q.sub + 1'b1;
                    end
                end
                RX_HOLD: if (line) d.st = RX_IDLE;
                default: d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.sync <= '1;
        end else begin
            q <= d;
        end
    end

    assign valid = q.valid;
    assign data  = q.data;
    assign perr  = q.perr;
    assign ferr  = q.ferr;
endmodule

// File: rtl/async_framer.sv
module async_framer
    import framer_pkg::*;
#(
    parameter int LINE_ID = 0,
    parameter int DATA_W  = 8,
    parameter int OS_RATE = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [15:0]            cfg_word,
    input  logic [SPEED_CODES-1:0] os_ticks,
    input  logic                   tx_load,
    input  logic [DATA_W-1:0]      tx_data,
    input  logic                   tx_break,
    output logic                   tx_busy,
    output logic                   txd,
    input  logic                   rxd,
    output logic                   rx_valid,
    output logic [DATA_W-1:0]      rx_data,
    output logic                   rx_perr,
    output logic                   rx_ferr
);
    line_cfg_t  cfg_q;
    logic       tick;
    logic       cfg_rx_en;
    logic [1:0] cfg_len;

    assign tick      = os_ticks[cfg_q.speed];
    assign cfg_rx_en = cfg_q.rx_en;
    assign cfg_len   = cfg_q.len;

    framer_cfg #(.LINE_ID(LINE_ID)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .word(cfg_word), .cfg(cfg_q)
    );

    framer_tx #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) u_tx (
        .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .tick(tick), .load(tx_load),
        .data(tx_data), .brk(tx_break), .busy(tx_busy), .txd(txd)
    );

    framer_rx #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) u_rx (
        .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .tick(tick), .rxd(rxd),
        .valid(rx_valid), .data(rx_data), .perr(rx_perr), .ferr(rx_ferr)
    );
endmodule

// File: rtl/async_framer_chk.sv
module async_framer_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_load,
    input logic              tx_busy,
    input logic              tx_break,
    input logic              txd,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data,
    input logic              cfg_rx_en,
    input logic [1:0]        cfg_len
);
    AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        tx_break |-> !txd); // R5

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && !tx_break) |-> txd); // R6

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_busy) && !tx_break) |-> !txd); // R2

    AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load && !tx_busy) |=> tx_busy); // R4

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R7

    AST_RX_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_rx_en) |-> !rx_valid); // R10

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && $past(cfg_len) == 2'b00) |-> rx_data[DATA_W-1:DATA_W-3] == '0); // R7
endmodule

bind async_framer async_framer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_load(tx_load), .tx_busy(tx_busy),
    .tx_break(tx_break), .txd(txd), .rx_valid(rx_valid), .rx_data(rx_data),
    .cfg_rx_en(cfg_rx_en), .cfg_len(cfg_len)
);

// File: tb/async_framer_tb.sv
module async_framer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_word = '0;
    logic [15:0] os_ticks;
    logic        tx_load = 1'b0;
    logic [7:0]  tx_data = '0;
    logic        tx_break = 1'b0;
    logic        tx_busy, txd;
    logic        rxd = 1'b1;
    logic        rx_valid;
    logic [7:0]  rx_data;
    logic        rx_perr, rx_ferr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic half_tick = 1'b0;
    logic [9:0] exp_q[$];

    always #5 clk = ~clk;

    // Speed 0xF: tick every cycle; 0xE: every other cycle; others never
    always @(posedge clk) begin
        half_tick <= ~half_tick;
        cycles    <= cycles + 1;
    end
    assign os_ticks = {1'b1, half_tick, 14'b0};

    async_framer u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
        .os_ticks(os_ticks), .tx_load(tx_load), .tx_data(tx_data),
        .tx_break(tx_break), .tx_busy(tx_busy), .txd(txd), .rxd(rxd),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: every valid must match the oldest expected item
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected rx_valid", {rx_data, rx_perr, rx_ferr}, 0);
            end else begin
                logic [9:0] e;
                e = exp_q.pop_front();
                check({rx_data, rx_perr, rx_ferr} == e, "R7/R8/R9 rx item",
                      {rx_data, rx_perr, rx_ferr}, e);
            end
        end
    end

    always @(posedge clk) begin
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic write_cfg(input int line, input int nd, input bit stop2, input bit par,
                             input bit odd, input int speed, input bit rxen);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_word = {3'b000, rxen, 4'(speed), odd, par, stop2, 2'(nd - 5), 1'b0, 2'(line)};
        @(negedge clk);
        cfg_we   = 1'b0;
        cfg_word = '0;
    endtask

    // Load a character and sample txd mid-bit against an independently built frame
    task automatic tx_check(input logic [7:0] d, input int nd, input bit par, input bit odd,
                            input int nstop, input int bcyc, input string req);
        bit exp_bits[12];
        int n;
        bit p;
        n = 0;
        p = odd;
        exp_bits[n++] = 1'b0;
        for (int i = 0; i < nd; i++) begin
            exp_bits[n++] = d[i];
            p ^= d[i];
        end
        if (par) exp_bits[n++] = p;
        for (int i = 0; i < nstop; i++) exp_bits[n++] = 1'b1;
        @(negedge clk);
        tx_load = 1'b1;
        tx_data = d;
        @(posedge clk);
        #1 tx_load = 1'b0;
        for (int i = 0; i < n; i++) begin
            repeat ((i == 0) ? bcyc / 2 : bcyc) @(posedge clk);
            @(negedge clk);
            check(txd == exp_bits[i], req, txd, exp_bits[i]);
        end
        repeat (bcyc) @(posedge clk);
        @(negedge clk);
        check(!tx_busy && txd, "R4/R6 frame end idle", {tx_busy, txd}, 1);
    endtask

    task automatic drive_bit(input bit b, input int ncyc);
        @(posedge clk);
        #1 rxd = b;
        repeat (ncyc - 1) @(posedge clk);
    endtask

    task automatic rx_frame(input logic [7:0] d, input int nd, input bit par, input bit odd,
                            input int nstop, input bit bad_par, input bit bad_stop,
                            input bit expect_it);
        logic [7:0] m;
        bit p;
        m = d & 8'((1 << nd) - 1);
        p = odd ^ (^m) ^ bad_par;
        if (expect_it) exp_q.push_back({m, bad_par & par, bad_stop});
        drive_bit(1'b0, 16);
        for (int i = 0; i < nd; i++) drive_bit(d[i], 16);
        if (par) drive_bit(p, 16);
        drive_bit(!bad_stop, 16);
        for (int i = 1; i < nstop; i++) drive_bit(1'b1, 16);
        drive_bit(1'b1, 32);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(txd == 1'b1 && !tx_busy && !rx_valid, "R12 reset outputs",
              {txd, tx_busy, rx_valid}, 3'b100);

        // R12 default format: 8 bits, 1 stop, no parity, full speed
        tx_check(8'hA5, 8, 0, 0, 1, 16, "R12 default frame");

        // R2 R3 5-bit even parity, 2 stops
        write_cfg(0, 5, 1, 1, 0, 15, 0);
        tx_check(8'hF6, 5, 1, 0, 2, 16, "R2 R3 5-bit even parity");
        // R3 odd parity, 7 bits
        write_cfg(0, 7, 0, 1, 1, 15, 0);
        tx_check(8'h5A, 7, 1, 1, 1, 16, "R3 7-bit odd parity");

        // R1 word for another line must not change the format
        write_cfg(1, 5, 1, 0, 0, 14, 0);
        tx_check(8'h3C, 7, 1, 1, 1, 16, "R1 other line ignored");

        // R11 speed code 0xE halves the bit rate
        write_cfg(0, 8, 0, 0, 0, 14, 0);
        tx_check(8'h81, 8, 0, 0, 1, 32, "R11 speed select");

        // R4 load while busy ignored
        write_cfg(0, 8, 0, 0, 0, 15, 0);
        fork
            tx_check(8'hC3, 8, 0, 0, 1, 16, "R4 frame unchanged by second load");
            begin
                repeat (30) @(negedge clk);
                check(tx_busy, "R4 busy mid frame", tx_busy, 1);
                tx_load = 1'b1;
                tx_data = 8'h00;
                @(negedge clk);
                tx_load = 1'b0;
            end
        join

        // R5 break forces space
        @(negedge clk);
        tx_break = 1'b1;
        @(negedge clk);
        check(txd == 1'b0, "R5 break low", txd, 0);
        tx_break = 1'b0;
        @(negedge clk);
        check(txd == 1'b1, "R6 idle after break", txd, 1);

        // R10 receiver off: a frame on rxd produces nothing
        rx_frame(8'h55, 8, 0, 0, 1, 0, 0, 0);

        // R7 receive 8-bit and 5-bit characters
        write_cfg(0, 8, 0, 0, 0, 15, 1);
        rx_frame(8'h96, 8, 0, 0, 1, 0, 0, 1);
        write_cfg(0, 5, 0, 0, 0, 15, 1);
        rx_frame(8'hFF, 5, 0, 0, 1, 0, 0, 1);

        // R8 parity good then bad, odd sense, 2 stops
        write_cfg(0, 7, 1, 1, 1, 15, 1);
        rx_frame(8'h5A, 7, 1, 1, 2, 0, 0, 1);
        rx_frame(8'h33, 7, 1, 1, 2, 1, 0, 1);
        write_cfg(0, 6, 0, 1, 0, 15, 1);
        rx_frame(8'h2B, 6, 1, 0, 1, 1, 0, 1);

        // R9 framing error, then a held break reported once
        write_cfg(0, 8, 0, 0, 0, 15, 1);
        rx_frame(8'h7E, 8, 0, 0, 1, 0, 1, 1);
        exp_q.push_back({8'h00, 1'b0, 1'b1});
        drive_bit(1'b0, 16 * 20);
        drive_bit(1'b1, 48);
        rx_frame(8'h42, 8, 0, 0, 1, 0, 0, 1);

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R7 R9 R10 all items delivered", exp_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule